// File: doc/BRIEF.md
# G.711 Companding Stage

This stage sits between a serial port's shift registers and its word buffers. On the transmit side it takes a linear two's-complement sample and turns it into an 8-bit G.711 code. On the receive side it takes an 8-bit G.711 code and expands it back into a linear sample. Each direction has its own law select, which picks µ-law, A-law or a plain pass-through. Serial framing, slot selection and DMA belong to the surrounding port and are not part of this block.

Both directions move a word through exactly one register. Enabling companding therefore costs no cycle compared with the pass-through path. The law select for a direction is captured together with each word, so a change to the select takes effect at the next word boundary. The registered result holds its value until the next word arrives.

Top module: `g711_compander`

## Requirements
- R1: While reset is asserted, both result words and both result-valid flags are zero.
- R2: A word presented with its valid high appears on the matching result one clock later, with result-valid high for that single cycle. The delay is the same in every law setting.
- R3: A law select of 2'b00 or 2'b11 passes the full 16-bit word through unchanged, in either direction.
- R4: Law select 2'b01 on transmit produces µ-law. The encoder uses the top 14 bits of the sample, clamps the magnitude at 8159, adds a bias of 33 and inverts the code. The 8-bit code {sign, 3-bit segment, 4-bit mantissa} lands in result bits 7:0 and bits 15:8 are zero. A non-negative sample has sign bit 1.
- R5: Law select 2'b10 on transmit produces A-law. The encoder uses the top 13 bits of the sample, and a negative sample uses the one's complement of its magnitude. The 7-bit {segment, mantissa} is XORed with 7'h55. Bit 7 is 1 for a non-negative sample. The code lands in bits 7:0 and bits 15:8 are zero.
- R6: Law select 2'b01 on receive expands bits 7:0 of the input as a µ-law code. The result is the left-justified 16-bit value at the midpoint of the code's interval. Bits 15:8 of the input are ignored.
- R7: Law select 2'b10 on receive removes the 8'h55 toggle and expands bits 7:0 as an A-law code to the left-justified 16-bit midpoint value.
- R8: The transmit and receive law selects act independently. Words may be presented to both directions in the same cycle.
- R9: The law select is taken from the cycle in which the word is presented. While valid is low, a result and its law do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txValid | input | 1 | Transmit word present |
| txMode | input | 2 | Transmit law: 00 pass, 01 µ-law, 10 A-law, 11 pass |
| txSample | input | 16 | Linear transmit sample |
| rxValid | input | 1 | Receive word present |
| rxMode | input | 2 | Receive law, same encoding as txMode |
| rxWord | input | 16 | Received code (bits 7:0) or raw word |
| txOut | output | 16 | Encoded code or passed sample |
| txOutValid | output | 1 | Transmit result updated this cycle |
| rxOut | output | 16 | Expanded sample or passed word |
| rxOutValid | output | 1 | Receive result updated this cycle |

## Verification
Every result, whether encoded, expanded or passed through, is due exactly one rising edge after its word is driven. The bench drives inputs on the falling edge and samples the outputs on the very next falling edge. The check therefore lands half a cycle after the capturing edge, in every law setting.

Idle cycles are checked at that same point. The bench confirms that valid has dropped and that the previous result is still present. All 256 codes of each law are expanded. Encoder inputs are swept around every segment edge of both laws, and randomly mixed traffic runs against bench model functions.

// File: rtl/g711_pkg.sv
package g711_pkg;

  typedef enum logic [1:0] {
    LAW_PASS = 2'b00,
    LAW_MU   = 2'b01,
    LAW_A    = 2'b10
  } lawSel_e;

  typedef struct packed {
    logic    txLoad;
    logic    rxLoad;
    lawSel_e txLaw;
    lawSel_e rxLaw;
  } compStrobe_t;

  localparam int CODE_W    = 8;
  localparam int MU_IN_W   = 14;
  localparam int A_IN_W    = 13;
  localparam int LIN_W     = 16;
  localparam logic [14:0] MU_CLIP = 15'd8159;
  localparam logic [14:0] MU_BIAS = 15'd33;

  // µ-law: 14-bit linear in, inverted 8-bit code out
  function automatic logic [CODE_W-1:0] muEncode(input logic [MU_IN_W-1:0] lin);
    logic [14:0] mag;
    logic [3:0]  seg;
    logic [7:0]  raw;
    mag = lin[MU_IN_W-1] ? (~{1'b1, lin} + 15'd1) : {1'b0, lin};
    if (mag > MU_CLIP) mag = MU_CLIP;
    mag = mag + MU_BIAS;
    seg = 4'd0;
    for (int i = 0; i < 8; i++) begin
      if (mag >= (15'd64 << i)) seg = seg + 4'd1;
    end
    if (seg[3]) raw = 8'h7F;
    else        raw = {1'b0, seg[2:0], 4'(mag >> (seg + 4'd1))};
    return raw ^ (lin[MU_IN_W-1] ? 8'h7F : 8'hFF);
  endfunction

  // A-law: 13-bit linear in, 0x55-toggled code out
  function automatic logic [CODE_W-1:0] aEncode(input logic [A_IN_W-1:0] lin);
    logic [11:0] mag;
    logic [2:0]  seg;
    logic [3:0]  mant;
    mag = lin[A_IN_W-1] ? ~lin[11:0] : lin[11:0];
    seg = 3'd0;
    for (int i = 0; i < 7; i++) begin
      if (mag >= (12'd32 << i)) seg = seg + 3'd1;
    end
    mant = (seg < 3'd2) ? mag[4:1] : 4'(mag >> seg);
    return {~lin[A_IN_W-1], seg ^ 3'b101, mant ^ 4'b0101};
  endfunction

  function automatic logic [LIN_W-1:0] muDecode(input logic [CODE_W-1:0] code);
    logic [7:0]  u;
    logic [15:0] t;
    u = ~code;
    t = ({9'd0, u[3:0], 3'b000} + 16'd132) << u[6:4];
    return u[7] ? (16'd132 - t) : (t - 16'd132);
  endfunction

  function automatic logic [LIN_W-1:0] aDecode(input logic [CODE_W-1:0] code);
    logic [7:0]  a;
    logic [15:0] t;
    a = code ^ 8'h55;
    t = {8'd0, a[3:0], 4'b0000} + ((a[6:4] == 3'd0) ? 16'd8 : 16'd264);
    if (a[6:4] > 3'd1) t = t << (a[6:4] - 3'd1);
    return a[7] ? t : (~t + 16'd1);
  endfunction

endpackage

// File: rtl/g711_ctrl.sv
module g711_ctrl
  import g711_pkg::*;
(
  input  logic        txValid,
  input  logic [1:0]  txMode,
  input  logic        rxValid,
  input  logic [1:0]  rxMode,
  output compStrobe_t strobe
);

  function automatic lawSel_e decodeLaw(input logic [1:0] sel);
    case (sel)
      2'b01:   return LAW_MU;
      2'b10:   return LAW_A;
      default: return LAW_PASS;
    endcase
  endfunction

  always_comb begin
    strobe.txLoad = txValid;
    strobe.rxLoad = rxValid;
    strobe.txLaw  = decodeLaw(txMode);
    strobe.rxLaw  = decodeLaw(rxMode);
  end

endmodule

// File: rtl/g711_datapath.sv
module g711_datapath
  import g711_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  compStrobe_t         strobe,
  input  logic [SAMPLE_W-1:0] txSample,
  input  logic [SAMPLE_W-1:0] rxWord,
  output logic [SAMPLE_W-1:0] txOut,
  output logic                txOutValid,
  output logic [SAMPLE_W-1:0] rxOut,
  output logic                rxOutValid
);

  localparam int PAD = SAMPLE_W - LIN_W;

  logic [SAMPLE_W-1:0] txNext;
  logic [SAMPLE_W-1:0] rxNext;
  logic [CODE_W-1:0]   muCode;
  logic [CODE_W-1:0]   aCode;
  logic [LIN_W-1:0]    muLin;
  logic [LIN_W-1:0]    aLin;

  always_comb begin
    muCode = muEncode(txSample[SAMPLE_W-1 -: MU_IN_W]);
    aCode  = aEncode(txSample[SAMPLE_W-1 -: A_IN_W]);
    muLin  = muDecode(rxWord[CODE_W-1:0]);
    aLin   = aDecode(rxWord[CODE_W-1:0]);
  end

  always_comb begin
    case (strobe.txLaw)
      LAW_MU:  txNext = SAMPLE_W'(muCode);
      LAW_A:   txNext = SAMPLE_W'(aCode);
      default: txNext = txSample;
    endcase
    case (strobe.rxLaw)
      LAW_MU:  rxNext = SAMPLE_W'(muLin) << PAD;
      LAW_A:   rxNext = SAMPLE_W'(aLin) << PAD;
      default: rxNext = rxWord;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOut      <= '0;
      txOutValid <= 1'b0;
      rxOut      <= '0;
      rxOutValid <= 1'b0;
    end else begin
      txOutValid <= strobe.txLoad;
      rxOutValid <= strobe.rxLoad;
      if (strobe.txLoad) txOut <= txNext;
      if (strobe.rxLoad) rxOut <= rxNext;
    end
  end

endmodule

// File: rtl/g711_compander.sv
module g711_compander
  import g711_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txValid,
  input  logic [1:0]          txMode,
  input  logic [SAMPLE_W-1:0] txSample,
  input  logic                rxValid,
  input  logic [1:0]          rxMode,
  input  logic [SAMPLE_W-1:0] rxWord,
  output logic [SAMPLE_W-1:0] txOut,
  output logic                txOutValid,
  output logic [SAMPLE_W-1:0] rxOut,
  output logic                rxOutValid
);

  compStrobe_t strobe;

  g711_ctrl i_ctrl (
    .txValid (txValid),
    .txMode  (txMode),
    .rxValid (rxValid),
    .rxMode  (rxMode),
    .strobe  (strobe)
  );

  g711_datapath #(.SAMPLE_W(SAMPLE_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txSample   (txSample),
    .rxWord     (rxWord),
    .txOut      (txOut),
    .txOutValid (txOutValid),
    .rxOut      (rxOut),
    .rxOutValid (rxOutValid)
  );

endmodule

// File: rtl/g711_compander_chk.sv
module g711_compander_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                txValid,
  input logic [1:0]          txMode,
  input logic [SAMPLE_W-1:0] txSample,
  input logic                rxValid,
  input logic [1:0]          rxMode,
  input logic [SAMPLE_W-1:0] rxWord,
  input logic [SAMPLE_W-1:0] txOut,
  input logic                txOutValid,
  input logic [SAMPLE_W-1:0] rxOut,
  input logic                rxOutValid
);

  AST_TX_LATENCY: assert property (@(posedge clk) disable iff (!rstN) txValid |=> txOutValid); // R2
  AST_RX_LATENCY: assert property (@(posedge clk) disable iff (!rstN) rxValid |=> rxOutValid); // R2
  AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rstN) !txValid |=> !txOutValid && $stable(txOut)); // R9
  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rstN) !rxValid |=> !rxOutValid && $stable(rxOut)); // R9
  AST_TX_PASS: assert property (@(posedge clk) disable iff (!rstN)
    txValid && (txMode == 2'b00 || txMode == 2'b11) |=> txOut == $past(txSample)); // R3
  AST_RX_PASS: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && (rxMode == 2'b00 || rxMode == 2'b11) |=> rxOut == $past(rxWord)); // R3
  AST_TX_CODE_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    txValid && (txMode == 2'b01 || txMode == 2'b10) |=> txOut[SAMPLE_W-1:8] == '0); // R4
  AST_MU_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txMode == 2'b01 |=> txOut[7] == !$past(txSample[SAMPLE_W-1])); // R4
  AST_A_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txMode == 2'b10 |=> txOut[7] == !$past(txSample[SAMPLE_W-1])); // R5

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_CLEAR: assert (!txOutValid && !rxOutValid); // R1
    end
  end

endmodule

bind g711_compander g711_compander_chk #(.SAMPLE_W(SAMPLE_W)) i_chk (.*);

// File: tb/test_g711_compander.sv
module test_g711_compander;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txValid = 1'b0;
  logic [1:0]  txMode = 2'b00;
  logic [15:0] txSample = '0;
  logic        rxValid = 1'b0;
  logic [1:0]  rxMode = 2'b00;
  logic [15:0] rxWord = '0;
  logic [15:0] txOut;
  logic        txOutValid;
  logic [15:0] rxOut;
  logic        rxOutValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [15:0] lastTx = '0;
  logic [15:0] lastRx = '0;

  always #4 clk = ~clk;

  g711_compander i_g711_compander (.*);

  function automatic int muEnc(input logic [15:0] x);
    int v, msk, e;
    v = $signed(x) >>> 2;
    if (v < 0) begin v = -v; msk = 'h7F; end else msk = 'hFF;
    if (v > 8159) v = 8159;
    v = v + 33;
    e = 0;
    while (e < 8 && v > ((64 << e) - 1)) e++;
    if (e == 8) return 'h7F ^ msk;
    return ((e << 4) | ((v >> (e + 1)) & 15)) ^ msk;
  endfunction

  function automatic int aEnc(input logic [15:0] x);
    int v, msk, e, m;
    v = $signed(x) >>> 3;
    if (v >= 0) msk = 'hD5;
    else begin msk = 'h55; v = -v - 1; end
    e = 0;
    while (e < 7 && v >= (32 << e)) e++;
    m = (e < 2) ? ((v >> 1) & 15) : ((v >> e) & 15);
    return ((e << 4) | m) ^ msk;
  endfunction

  function automatic logic [15:0] muDec(input int c);
    int u, e, m, mag;
    u = (~c) & 255;
    e = (u >> 4) & 7;
    m = u & 15;
    mag = 4 * (((2 * m + 33) << e) - 33);
    return 16'((u & 'h80) != 0 ? -mag : mag);
  endfunction

  function automatic logic [15:0] aDec(input int c);
    int a, e, m, mag;
    a = (c ^ 'h55) & 255;
    e = (a >> 4) & 7;
    m = a & 15;
    mag = (e == 0) ? (m * 16 + 8) : ((m * 16 + 264) << (e - 1));
    return 16'((a & 'h80) != 0 ? mag : -mag);
  endfunction

  function automatic logic [15:0] expTx(input logic [1:0] md, input logic [15:0] s);
    case (md)
      2'b01:   return 16'(muEnc(s));
      2'b10:   return 16'(aEnc(s));
      default: return s;
    endcase
  endfunction

  function automatic logic [15:0] expRx(input logic [1:0] md, input logic [15:0] w);
    case (md)
      2'b01:   return muDec(int'(w[7:0]));
      2'b10:   return aDec(int'(w[7:0]));
      default: return w;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, result due one rising edge later, sampled at next falling edge
  task automatic step(input bit tv, input logic [1:0] tm, input logic [15:0] ts,
                      input bit rv, input logic [1:0] rm, input logic [15:0] rw, input string req);
    logic [15:0] et, er;
    txValid = tv; txMode = tm; txSample = ts;
    rxValid = rv; rxMode = rm; rxWord = rw;
    et = tv ? expTx(tm, ts) : lastTx;
    er = rv ? expRx(rm, rw) : lastRx;
    @(negedge clk);
    check(txOutValid == tv, {req, " R2 txOutValid"}, 16'(txOutValid), 16'(tv));
    check(rxOutValid == rv, {req, " R2 rxOutValid"}, 16'(rxOutValid), 16'(rv));
    check(txOut == et, {req, " txOut"}, txOut, et);
    check(rxOut == er, {req, " rxOut"}, rxOut, er);
    lastTx = et;
    lastRx = er;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txOut == 0 && !txOutValid, "R1 tx reset", txOut, 16'h0);
    check(rxOut == 0 && !rxOutValid, "R1 rx reset", rxOut, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R6 R7: all 256 codes, both laws; R8: tx runs a different law at the same time
    for (int c = 0; c < 256; c++) begin
      step(1, 2'b10, 16'(c * 257), 1, 2'b01, {8'(c ^ 'hA5), 8'(c)}, "R6 R8");
      step(1, 2'b01, 16'(c * 131 - 16000), 1, 2'b10, 16'(c), "R7 R8");
    end

    // R4: µ-law segment edges (bias-shifted), both signs, plus low-bit offsets
    for (int e = 0; e < 8; e++) begin
      for (int d = -3; d <= 3; d++) begin
        int mag = ((64 << e) - 33 + d) * 4;
        step(1, 2'b01, 16'(mag), 0, 2'b00, 16'h0, "R4 edge+");
        step(1, 2'b01, 16'(-mag - 1), 0, 2'b00, 16'h0, "R4 edge-");
      end
    end
    // R5: A-law segment edges
    for (int e = 0; e < 8; e++) begin
      for (int d = -3; d <= 3; d++) begin
        int mag = ((32 << e) + d) * 8;
        step(1, 2'b10, 16'(mag), 0, 2'b00, 16'h0, "R5 edge+");
        step(1, 2'b10, 16'(-mag), 0, 2'b00, 16'h0, "R5 edge-");
      end
    end
    // extremes: R4 clamp, R5 full scale
    step(1, 2'b01, 16'h7FFF, 0, 2'b00, 16'h0, "R4 max");
    step(1, 2'b01, 16'h8000, 0, 2'b00, 16'h0, "R4 min");
    step(1, 2'b01, 16'h0000, 0, 2'b00, 16'h0, "R4 zero");
    step(1, 2'b01, 16'hFFFF, 0, 2'b00, 16'h0, "R4 minus1");
    step(1, 2'b10, 16'h7FFF, 0, 2'b00, 16'h0, "R5 max");
    step(1, 2'b10, 16'h8000, 0, 2'b00, 16'h0, "R5 min");
    step(1, 2'b10, 16'hFFFF, 0, 2'b00, 16'h0, "R5 minus1");

    // R3: pass-through with both pass codes
    step(1, 2'b00, 16'hBEEF, 1, 2'b11, 16'h1234, "R3 pass");
    step(1, 2'b11, 16'h8001, 1, 2'b00, 16'hFFFF, "R3 pass");
    // R9: idle holds the previous result even when the mode changes
    step(0, 2'b01, 16'h4000, 0, 2'b10, 16'h0055, "R9 hold");
    step(0, 2'b10, 16'h0000, 0, 2'b01, 16'h00FF, "R9 hold");
    // R9: the new mode takes effect with the very next word
    step(1, 2'b01, 16'h4000, 1, 2'b10, 16'h0055, "R9 switch");

    // random mix (fixed seed)
    void'($urandom(32'd711));
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) != 0, 2'($urandom), 16'($urandom),
           ($urandom % 4) != 0, 2'($urandom), 16'($urandom), "R8 R9 random");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule